// File: doc/BRIEF.md
# Paddle-and-Ball Game Renderer

This block holds the whole state of a one-player bouncing-ball game and turns the raster position of a display into a colour. It sits downstream of a sync generator, which supplies the pixel coordinates and a visible-area flag. It also takes two debounced push-button levels, which move a vertical bar (the paddle) up and down along the left side of a 1024 by 768 screen.

A 50 by 50 square (the ball) travels diagonally. Once per frame the ball moves and bounces off the top, bottom and right edges. It also bounces off the paddle when it touches the paddle while heading left. If it slips past the paddle to the left edge, the ball starts again from the middle of the screen. All motion happens on a single pixel-clock cycle at the start of vertical blanking, so a visible frame never shows a half-updated scene. The colour output is registered and lags the coordinates by one clock.

Top module: `pong_render`

## Requirements
- R1: After reset the ball's top-left corner is at (487, 359) and it moves right and down. The paddle occupies columns 20 to 39 with its top row at 334, so its bottom row is 433.
- R2: Whenever the visible-area flag is low, the colour output becomes 0 (black) one cycle later.
- R3: Ball and paddle positions change only on the clock edge at which the coordinates are exactly x = 1024, y = 768. At any other coordinate they are held, whatever the buttons do.
- R4: Each frame the ball moves 4 pixels in each axis. Moving right, a step reaching x ≥ 974 sets x to 974 and turns the ball left. Moving down, a step reaching y ≥ 718 sets y to 718 and turns it up. Moving up from y ≤ 4 sets y to 0 and turns it down.
- R5: At a frame update, up alone lowers the paddle top row by 8 and stops at 0. Down alone raises it by 8 and stops at 668. Both buttons pressed, or neither, leaves it where it is.
- R6: If the ball is moving left and its rectangle overlaps the paddle's rectangle (before the paddle moves), the ball turns right. Its x stays the same for that frame, and its vertical step still applies.
- R7: If the ball is moving left, does not overlap the paddle, and has x < 4, the next update puts it at (487, 359) moving right, with its vertical direction unchanged.
- R8: Colour encoding is 12-bit, with red in bits 11:8, green in 7:4 and blue in 3:0. The paddle is 12'hFFF, the ball 12'hF00 and the background 12'h00F. The output reflects the coordinates of the previous clock.
- R9: An object covers x from its left column up to but excluding left plus width, and the same for y. Where paddle and ball overlap, the paddle colour wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| px_x | input | 11 | Current horizontal pixel count |
| px_y | input | 11 | Current vertical line count |
| vid_en | input | 1 | High inside the visible 1024x768 area |
| btn_up | input | 1 | Debounced level, moves paddle toward row 0 |
| btn_dn | input | 1 | Debounced level, moves paddle toward the bottom |
| rgb | output | 12 | Registered pixel colour |

## Verification
The positions are only visible as coloured rectangles. A wrong ball or paddle register therefore shows up as a wrong colour at that object's corner pixels or just outside them, on the first probe after the frame update that corrupted it. A wrong direction bit has no effect until the next update, when the rectangle lands 8 pixels away from where it should be. A faulty hit or miss decision is exposed within a few frames as the ball either passing through the paddle or reappearing at the centre.

// File: rtl/pong_pkg.sv
package pong_pkg;
  parameter int unsigned COORD_W = 11;
  parameter int unsigned RGB_W   = 12;
  typedef logic [COORD_W-1:0] coord_t;
  typedef logic [RGB_W-1:0]   rgb_t;
endpackage

// File: rtl/pong_paddle_ctl.sv
module pong_paddle_ctl
  import pong_pkg::*;
#(
  parameter int unsigned SCR_H    = 768,
  parameter int unsigned PAD_H    = 100,
  parameter int unsigned PAD_STEP = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   btn_up,
  input  logic   btn_dn,
  output coord_t pad_y
);
  localparam coord_t TOP_MAX = coord_t'(SCR_H - PAD_H);
  localparam coord_t START_Y = coord_t'((SCR_H - PAD_H) / 2);
  localparam coord_t STEP_C  = coord_t'(PAD_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_y <= START_Y;
    end else if (tick) begin
      if (btn_up && !btn_dn) begin
        pad_y <= (pad_y < STEP_C) ? '0 : pad_y - STEP_C;
      end else if (btn_dn && !btn_up) begin
        pad_y <= (pad_y > TOP_MAX - STEP_C) ? TOP_MAX : pad_y + STEP_C;
      end
    end
  end

  // R3: paddle frozen between frame updates
  a_r3_pad_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> $stable(pad_y));
  // R5: paddle stays on screen
  a_r5_pad_range: assert property (@(posedge clk) disable iff (rst)
    pad_y <= TOP_MAX);
endmodule

// File: rtl/pong_ball_motion.sv
module pong_ball_motion
  import pong_pkg::*;
#(
  parameter int unsigned SCR_W     = 1024,
  parameter int unsigned SCR_H     = 768,
  parameter int unsigned BALL_SZ   = 50,
  parameter int unsigned BALL_STEP = 4,
  parameter int unsigned PAD_X     = 20,
  parameter int unsigned PAD_W     = 20,
  parameter int unsigned PAD_H     = 100
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  coord_t pad_y,
  output coord_t ball_x,
  output coord_t ball_y
);
  localparam coord_t X_MAX   = coord_t'(SCR_W - BALL_SZ);
  localparam coord_t Y_MAX   = coord_t'(SCR_H - BALL_SZ);
  localparam coord_t START_X = coord_t'((SCR_W - BALL_SZ) / 2);
  localparam coord_t START_Y = coord_t'((SCR_H - BALL_SZ) / 2);
  localparam coord_t STEP_C  = coord_t'(BALL_STEP);
  localparam coord_t SZ_C    = coord_t'(BALL_SZ);
  localparam coord_t PAD_L   = coord_t'(PAD_X);
  localparam coord_t PAD_R   = coord_t'(PAD_X + PAD_W);
  localparam coord_t PAD_H_C = coord_t'(PAD_H);

  logic   go_right, go_down;
  logic   hit, miss;
  coord_t nx, ny;
  logic   n_right, n_down;

  always_comb begin
    hit  = !go_right && (ball_x < PAD_R) && (ball_x + SZ_C > PAD_L) &&
           (ball_y < pad_y + PAD_H_C) && (ball_y + SZ_C > pad_y);
    miss = !go_right && !hit && (ball_x < STEP_C);

    nx = ball_x;
    n_right = go_right;
    if (go_right) begin
      if (ball_x + STEP_C >= X_MAX) begin
        nx = X_MAX;
        n_right = 1'b0;
      end else begin
        nx = ball_x + STEP_C;
      end
    end else if (hit) begin
      n_right = 1'b1;
    end else if (miss) begin
      nx = START_X;
      n_right = 1'b1;
    end else begin
      nx = ball_x - STEP_C;
    end

    ny = ball_y;
    n_down = go_down;
    if (miss) begin
      ny = START_Y;
    end else if (go_down) begin
      if (ball_y + STEP_C >= Y_MAX) begin
        ny = Y_MAX;
        n_down = 1'b0;
      end else begin
        ny = ball_y + STEP_C;
      end
    end else if (ball_y <= STEP_C) begin
      ny = '0;
      n_down = 1'b1;
    end else begin
      ny = ball_y - STEP_C;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ball_x   <= START_X;
      ball_y   <= START_Y;
      go_right <= 1'b1;
      go_down  <= 1'b1;
    end else if (tick) begin
      ball_x   <= nx;
      ball_y   <= ny;
      go_right <= n_right;
      go_down  <= n_down;
    end
  end

  // R3: ball frozen between frame updates
  a_r3_ball_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(tick) |-> ($stable(ball_x) && $stable(ball_y)));
  // R4: ball never leaves the screen
  a_r4_ball_range: assert property (@(posedge clk) disable iff (rst)
    (ball_x <= X_MAX) && (ball_y <= Y_MAX));
  // R6: a paddle contact never lets the ball keep drifting left
  a_r6_hit_turns: assert property (@(posedge clk) disable iff (rst)
    (tick && hit) |=> (ball_x == $past(ball_x)));
endmodule

// File: rtl/pong_pixel_mux.sv
module pong_pixel_mux
  import pong_pkg::*;
#(
  parameter int unsigned BALL_SZ  = 50,
  parameter int unsigned PAD_X    = 20,
  parameter int unsigned PAD_W    = 20,
  parameter int unsigned PAD_H    = 100,
  parameter rgb_t        COL_PAD  = 12'hFFF,
  parameter rgb_t        COL_BALL = 12'hF00,
  parameter rgb_t        COL_BG   = 12'h00F
) (
  input  logic   clk,
  input  logic   rst,
  input  coord_t px_x,
  input  coord_t px_y,
  input  logic   vid_en,
  input  coord_t ball_x,
  input  coord_t ball_y,
  input  coord_t pad_y,
  output rgb_t   rgb
);
  localparam coord_t SZ_C    = coord_t'(BALL_SZ);
  localparam coord_t PAD_L   = coord_t'(PAD_X);
  localparam coord_t PAD_R   = coord_t'(PAD_X + PAD_W);
  localparam coord_t PAD_H_C = coord_t'(PAD_H);

  logic in_pad, in_ball;
  rgb_t colour;

  always_comb begin
    in_pad  = (px_x >= PAD_L) && (px_x < PAD_R) &&
              (px_y >= pad_y) && (px_y < pad_y + PAD_H_C);
    in_ball = (px_x >= ball_x) && (px_x < ball_x + SZ_C) &&
              (px_y >= ball_y) && (px_y < ball_y + SZ_C);
    if (!vid_en)      colour = '0;
    else if (in_pad)  colour = COL_PAD;
    else if (in_ball) colour = COL_BALL;
    else              colour = COL_BG;
  end

  always_ff @(posedge clk) begin
    if (rst) rgb <= '0;
    else     rgb <= colour;
  end

  // R2: blanking forces black on the following cycle
  a_r2_blank_black: assert property (@(posedge clk) disable iff (rst)
    !$past(vid_en) |-> (rgb == '0));
endmodule

// File: rtl/pong_render.sv
module pong_render
  import pong_pkg::*;
#(
  parameter int unsigned SCR_W     = 1024,
  parameter int unsigned SCR_H     = 768,
  parameter int unsigned BALL_SZ   = 50,
  parameter int unsigned BALL_STEP = 4,
  parameter int unsigned PAD_X     = 20,
  parameter int unsigned PAD_W     = 20,
  parameter int unsigned PAD_H     = 100,
  parameter int unsigned PAD_STEP  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [10:0] px_x,
  input  logic [10:0] px_y,
  input  logic        vid_en,
  input  logic        btn_up,
  input  logic        btn_dn,
  output logic [11:0] rgb
);
  localparam coord_t TICK_X = coord_t'(SCR_W);
  localparam coord_t TICK_Y = coord_t'(SCR_H);

  logic   tick;
  coord_t ball_x, ball_y, pad_y;

  assign tick = (px_x == TICK_X) && (px_y == TICK_Y);

  pong_paddle_ctl #(
    .SCR_H(SCR_H), .PAD_H(PAD_H), .PAD_STEP(PAD_STEP)
  ) paddle_i (
    .clk(clk), .rst(rst), .tick(tick),
    .btn_up(btn_up), .btn_dn(btn_dn), .pad_y(pad_y)
  );

  pong_ball_motion #(
    .SCR_W(SCR_W), .SCR_H(SCR_H), .BALL_SZ(BALL_SZ), .BALL_STEP(BALL_STEP),
    .PAD_X(PAD_X), .PAD_W(PAD_W), .PAD_H(PAD_H)
  ) ball_i (
    .clk(clk), .rst(rst), .tick(tick), .pad_y(pad_y),
    .ball_x(ball_x), .ball_y(ball_y)
  );

  pong_pixel_mux #(
    .BALL_SZ(BALL_SZ), .PAD_X(PAD_X), .PAD_W(PAD_W), .PAD_H(PAD_H)
  ) pix_i (
    .clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y), .vid_en(vid_en),
    .ball_x(ball_x), .ball_y(ball_y), .pad_y(pad_y), .rgb(rgb)
  );
endmodule

// File: tb/pong_render_tb.sv
module pong_render_tb_top;
  localparam int CLK_PERIOD = 16;
  localparam logic [11:0] C_PAD = 12'hFFF, C_BALL = 12'hF00, C_BG = 12'h00F;

  logic clk = 0, rst = 1, vid_en = 0, btn_up = 0, btn_dn = 0;
  logic [10:0] px_x = 0, px_y = 0;
  logic [11:0] rgb;
  int checks = 0, fails = 0;
  int bx, by, py, hits, misses;
  bit rt, dn;

  always #(CLK_PERIOD/2) clk = ~clk;

  pong_render dut_i (.clk(clk), .rst(rst), .px_x(px_x), .px_y(px_y),
    .vid_en(vid_en), .btn_up(btn_up), .btn_dn(btn_dn), .rgb(rgb));

  function automatic logic [11:0] exp_col(int x, int y, bit en);
    if (!en) return 12'h000;
    if (x >= 20 && x < 40 && y >= py && y < py + 100) return C_PAD;
    if (x >= bx && x < bx + 50 && y >= by && y < by + 50) return C_BALL;
    return C_BG;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic probe(int x, int y, bit en, string tag);
    logic [11:0] e;
    e = exp_col(x, y, en);
    @(negedge clk);
    px_x = 11'(x); px_y = 11'(y); vid_en = en;
    @(negedge clk);
    check(rgb == e, tag, int'(rgb), int'(e));
  endtask

  // reference model of one frame update (R4..R7)
  task automatic model_step(bit up, bit down);
    bit h, m;
    h = !rt && bx < 40 && bx + 50 > 20 && by < py + 100 && by + 50 > py;
    m = !rt && !h && bx < 4;
    if (rt) begin
      if (bx + 4 >= 974) begin bx = 974; rt = 0; end else bx += 4;
    end else if (h) begin rt = 1; hits++; end
    else if (m) begin bx = 487; rt = 1; misses++; end
    else bx -= 4;
    if (m) by = 359;
    else if (dn) begin
      if (by + 4 >= 718) begin by = 718; dn = 0; end else by += 4;
    end else if (by <= 4) begin by = 0; dn = 1; end
    else by -= 4;
    if (up && !down) py = (py < 8) ? 0 : py - 8;
    else if (down && !up) py = (py > 660) ? 668 : py + 8;
  endtask

  task automatic frame(bit up, bit down);
    @(negedge clk);
    px_x = 11'd1024; px_y = 11'd768; vid_en = 0; btn_up = up; btn_dn = down;
    model_step(up, down);
    @(negedge clk);
    px_x = 0; px_y = 0; btn_up = 0; btn_dn = 0;
  endtask

  task automatic check_scene(string tag);
    probe(bx, by, 1, tag);
    probe(bx + 49, by + 49, 1, tag);
    probe(bx + 50, by + 49, 1, tag);
    probe(bx + 49, by + 50, 1, tag);
    probe(20, py, 1, tag);
    probe(39, py + 99, 1, tag);
    probe(40, py + 50, 1, tag);
    probe(19, py, 1, tag);
    if (py + 100 < 768) probe(30, py + 100, 1, tag);
    if (bx < 40 && bx + 50 > 20 && by < py + 100 && by + 50 > py)
      probe(39, (by > py) ? by : py, 1, "R9 paddle over ball");
  endtask

  task automatic t_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    bx = 487; by = 359; py = 334; rt = 1; dn = 1; hits = 0; misses = 0;
    check_scene("R1 reset scene");
    probe(487, 359, 1, "R1 ball corner");
    probe(486, 359, 1, "R1 left of ball");
    probe(20, 433, 1, "R1 paddle bottom");
    probe(20, 434, 1, "R1 below paddle");
  endtask

  task automatic t_blank();
    probe(bx + 10, by + 10, 0, "R2 ball pixel blanked");
    probe(25, py + 5, 0, "R2 paddle pixel blanked");
    probe(600, 20, 0, "R2 background blanked");
  endtask

  task automatic t_latency();
    probe(600, 20, 1, "R8 background colour");
    @(negedge clk);
    px_x = 11'(bx + 5); px_y = 11'(by + 5); vid_en = 1;
    #1;
    check(rgb == C_BG, "R8 output lags one cycle", int'(rgb), int'(C_BG));
    @(negedge clk);
    check(rgb == C_BALL, "R8 ball colour", int'(rgb), int'(C_BALL));
  endtask

  task automatic t_no_tick();
    @(negedge clk);
    btn_dn = 1; btn_up = 0;
    px_x = 11'd1024; px_y = 11'd767; repeat (4) @(negedge clk);
    px_x = 11'd1023; px_y = 11'd768; repeat (4) @(negedge clk);
    px_x = 11'd0;    px_y = 11'd0;   repeat (4) @(negedge clk);
    btn_dn = 0;
    check_scene("R3 no update off tick");
  endtask

  task automatic t_paddle();
    for (int i = 0; i < 50; i++) begin frame(1, 0); check_scene("R5 paddle up"); end
    probe(20, 0, 1, "R5 clamp top");
    for (int i = 0; i < 90; i++) begin frame(0, 1); check_scene("R5 paddle down"); end
    probe(39, 767, 1, "R5 clamp bottom");
    for (int i = 0; i < 5; i++) begin frame(1, 1); check_scene("R5 both held"); end
  endtask

  task automatic t_walls();
    for (int i = 0; i < 200; i++) begin frame(0, 0); check_scene("R4 wall motion"); end
  endtask

  task automatic t_hit();
    int n;
    n = 0;
    while (hits == 0 && n < 800) begin
      bit u, d;
      u = py > by - 21; d = py < by - 29;
      frame(u, d); check_scene("R6 steering to hit"); n++;
    end
    check(hits > 0, "R6 hit reached", hits, 1);
    for (int i = 0; i < 15; i++) begin frame(0, 0); check_scene("R6 after bounce"); end
  endtask

  task automatic t_miss();
    int n;
    n = 0;
    while (misses == 0 && n < 1200) begin
      bit d;
      d = (by + 25 < py + 50);
      frame(!d, d); check_scene("R7 steering away"); n++;
    end
    check(misses > 0, "R7 miss reached", misses, 1);
    probe(487, 359, 1, "R7 restart corner");
    probe(486, 359, 1, "R7 left of restart");
    frame(0, 0); check_scene("R7 moves right after restart");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_blank();
    t_latency();
    t_no_tick();
    t_paddle();
    t_walls();
    t_hit();
    t_miss();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule